// File: doc/BRIEF.md
# Sleep-State Rail Sequencer

This block is the digital sequencer of a memory power controller. It runs on the clock of the switching regulator's oscillator. It reads two active-low sleep requests (light sleep and deep shutdown) and three qualification flags: bias-supply reset good, 12 V reset good, and the backfeed-switch trip flag. From these it drives the enables of four regulators:

- the main switching regulator;
- the standby LDO that holds the memory rail in light sleep;
- the termination LDO;
- the auxiliary LDO.

It also drives the backfeed-switch release, a soft-start request, a short that ties the termination reference to its rail, and the enable of the power-good comparator.

All five inputs first pass through a two-flop synchronizer. A cold start runs two soft-start intervals of `SS_CYCLES` clocks each: an amplifier-reset interval, then a ramp interval. Light-sleep entry drops the termination-side rails and brings in the standby LDO at once. The switcher then stops on the following oscillator period. Waking from light sleep waits for the 12 V rail, then runs one soft-start interval before the power-good comparator is enabled.

Top module: `sleep_pwr_seq`

## Requirements
- R1: Every input passes through two synchronizer flops. A change driven between rising edges is reflected at the outputs right after the third rising edge that follows it, and not before.
- R2: Reset and the shutdown state drive every output low: sw_en, sb_en, tt_en, aux_en, bkf_rel, ref_short, ss_req and pg_cmp_en.
- R3: Shutdown is left only when slp3_n, slp5_n, bias_por_ok, rail12_por_ok and bkf_trip are all high. The cold sequence that follows lasts exactly 2*SS_CYCLES clocks. During it sw_en, tt_en, aux_en, bkf_rel and ss_req are 1, and sb_en, ref_short and pg_cmp_en are 0.
- R4: A low slp3_n during the cold sequence has no effect; the cold sequence outputs stay as in R3 until the sequence ends.
- R5: In the active state sw_en, tt_en, aux_en, bkf_rel and pg_cmp_en are 1, and sb_en, ref_short and ss_req are 0.
- R6: slp3_n low in the active or wake state changes several outputs on the same edge: tt_en, aux_en, bkf_rel and pg_cmp_en go to 0, while sb_en and ref_short go to 1. sw_en stays 1 for exactly one more clock and then goes to 0.
- R7: In light sleep with slp3_n high, the block waits while rail12_por_ok is low. Once that flag is high it enters the wake state, with the same outputs as the cold sequence.
- R8: The wake state lasts exactly SS_CYCLES clocks with ss_req at 1 and pg_cmp_en at 0, and then moves to the active state.
- R9: slp5_n low in any state sends the block to shutdown on the edge that decodes it.
- R10: A low bias_por_ok in any state sends the block to shutdown. A low rail12_por_ok does the same in every state except shutdown and light sleep; in light sleep it is ignored.
- R11: pg_cmp_en is 1 only in the active state, and it rises only at the end of a soft-start interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp3_n | input | 1 | Light-sleep request, active low, asynchronous |
| slp5_n | input | 1 | Deep-shutdown request, active low, asynchronous |
| bias_por_ok | input | 1 | Bias supply above its reset threshold |
| rail12_por_ok | input | 1 | 12 V rail above its reset threshold |
| bkf_trip | input | 1 | Backfeed switch gate voltage has passed its trip level |
| sw_en | output | 1 | Switching regulator enable |
| sb_en | output | 1 | Standby LDO enable |
| tt_en | output | 1 | Termination LDO enable |
| aux_en | output | 1 | Auxiliary LDO enable |
| bkf_rel | output | 1 | 1 releases the backfeed switch drive, 0 pulls it low |
| ref_short | output | 1 | Ties the termination reference to its rail |
| ss_req | output | 1 | Soft-start request |
| pg_cmp_en | output | 1 | Power-good comparator enable |

## Verification
A wrong state shows up as a wrong combination of the eight outputs three edges after the input change that caused it. The switcher enable is the exception on sleep entry, where the drop is due one edge after the rest. A timer that is off by one shows at the point where ss_req falls and pg_cmp_en rises, so the bench measures the length of each soft-start interval by counting clocks. It does not only check the level of the outputs. The bench drives random input sequences with long holds, which walk the block through sleeps, wakes and dropouts in the middle of a sequence. A cycle-level model of the requirements catches any divergence on the clock where it first appears.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_COLD  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_SLEEP = 3'd4,
    ST_WAKE  = 3'd5
  } seq_st_t;

  typedef struct packed {
    logic sw;
    logic sb;
    logic tt;
    logic aux;
    logic bkf;
    logic shrt;
    logic ss;
    logic pg;
  } rail_ctl_t;

  // Number of clocks a timed state is held; zero for untimed states.
  function automatic int unsigned hold_cycles(seq_st_t st, int unsigned ss);
    case (st)
      ST_COLD: return 2 * ss;
      ST_WAKE: return ss;
      default: return 0;
    endcase
  endfunction

  function automatic rail_ctl_t ctl_of(seq_st_t st);
    rail_ctl_t c;
    c = '0;
    case (st)
      ST_COLD, ST_WAKE: begin
        c.sw = 1'b1; c.tt = 1'b1; c.aux = 1'b1; c.bkf = 1'b1; c.ss = 1'b1;
      end
      ST_RUN: begin
        c.sw = 1'b1; c.tt = 1'b1; c.aux = 1'b1; c.bkf = 1'b1; c.pg = 1'b1;
      end
      ST_DRAIN: begin
        c.sw = 1'b1; c.sb = 1'b1; c.shrt = 1'b1;
      end
      ST_SLEEP: begin
        c.sb = 1'b1; c.shrt = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr || limit == '0)   cnt_q <= '0;
    else                           cnt_q <= cnt_q + W'(1);
  end

  assign done = (limit != '0) && (cnt_q == limit - W'(1));

endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
  import sleep_seq_pkg::*;
(
  input  seq_st_t   st,
  output rail_ctl_t ctl
);

  always_comb ctl = ctl_of(st);

endmodule

// File: rtl/sleep_pwr_seq.sv
module sleep_pwr_seq
  import sleep_seq_pkg::*;
#(
  parameter int unsigned SS_CYCLES   = 2048,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slp3_n,
  input  logic slp5_n,
  input  logic bias_por_ok,
  input  logic rail12_por_ok,
  input  logic bkf_trip,
  output logic sw_en,
  output logic sb_en,
  output logic tt_en,
  output logic aux_en,
  output logic bkf_rel,
  output logic ref_short,
  output logic ss_req,
  output logic pg_cmp_en
);

  localparam int unsigned N_IN  = 5;
  localparam int unsigned CNT_W = $clog2(2 * SS_CYCLES) + 1;

  logic [N_IN-1:0] raw_in, syn_in;
  assign raw_in = {slp3_n, slp5_n, bias_por_ok, rail12_por_ok, bkf_trip};

  seq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  wire s3_s   = syn_in[4];
  wire s5_s   = syn_in[3];
  wire bias_s = syn_in[2];
  wire r12_s  = syn_in[1];
  wire trip_s = syn_in[0];

  seq_st_t st_q, st_d;
  logic    tmr_done;

  // Named events for the checker.
  wire force_off = !s5_s || !bias_s;
  wire rail_lost = !r12_s && (st_q != ST_OFF) && (st_q != ST_SLEEP);
  wire go_cold   = s3_s && s5_s && bias_s && r12_s && trip_s;
  wire go_wake   = s3_s && r12_s;

  always_comb begin
    st_d = st_q;
    if (force_off || rail_lost) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:   if (go_cold) st_d = ST_COLD;
        ST_COLD:  if (tmr_done) st_d = ST_RUN;
        ST_RUN:   if (!s3_s) st_d = ST_DRAIN;
        ST_DRAIN: st_d = ST_SLEEP;
        ST_SLEEP: if (go_wake) st_d = ST_WAKE;
        ST_WAKE: begin
          if (!s3_s)         st_d = ST_DRAIN;
          else if (tmr_done) st_d = ST_RUN;
        end
        default:  st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  wire             st_change = (st_d != st_q);
  logic [CNT_W-1:0] hold_lim;
  assign hold_lim = CNT_W'(hold_cycles(st_q, SS_CYCLES));

  seq_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st_change), .limit(hold_lim), .done(tmr_done)
  );

  rail_ctl_t ctl;
  seq_out_decode u_dec (.st(st_q), .ctl(ctl));

  assign sw_en     = ctl.sw;
  assign sb_en     = ctl.sb;
  assign tt_en     = ctl.tt;
  assign aux_en    = ctl.aux;
  assign bkf_rel   = ctl.bkf;
  assign ref_short = ctl.shrt;
  assign ss_req    = ctl.ss;
  assign pg_cmp_en = ctl.pg;

endmodule

// File: rtl/sleep_pwr_seq_chk.sv
module sleep_pwr_seq_chk
  import sleep_seq_pkg::*;
#(
  parameter int unsigned SS_CYCLES = 2048
) (
  input logic    clk,
  input logic    rst_n,
  input logic    s3_s,
  input logic    s5_s,
  input logic    bias_s,
  input logic    r12_s,
  input seq_st_t st_q,
  input logic    tmr_done,
  input logic    sw_en,
  input logic    sb_en,
  input logic    ss_req,
  input logic    pg_cmp_en
);

  logic [31:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (ss_req) run_cnt <= run_cnt + 32'd1;
    else             run_cnt <= '0;
  end

  assert_cold_ignores_s3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLD) && !s3_s && s5_s && bias_s && r12_s && !tmr_done |=> st_q == ST_COLD);

  assert_standby_before_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_en) |-> sw_en);

  assert_switch_off_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_en) && s5_s && bias_s && r12_s |=> !sw_en);

  assert_wake_needs_12v_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP) && !r12_s |=> st_q != ST_WAKE);

  assert_interval_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_cmp_en) |-> (run_cnt == 32'(SS_CYCLES)) || (run_cnt == 32'(2 * SS_CYCLES)));

  assert_deep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s5_s |=> st_q == ST_OFF);

  assert_bias_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_s |=> st_q == ST_OFF);

  assert_pg_after_ramp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_cmp_en) |-> $past(ss_req));

endmodule

bind sleep_pwr_seq sleep_pwr_seq_chk #(.SS_CYCLES(SS_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .s3_s(s3_s), .s5_s(s5_s), .bias_s(bias_s),
  .r12_s(r12_s), .st_q(st_q), .tmr_done(tmr_done), .sw_en(sw_en),
  .sb_en(sb_en), .ss_req(ss_req), .pg_cmp_en(pg_cmp_en)
);

// File: tb/sleep_pwr_seq_tb.sv
module sleep_pwr_seq_tb;

  localparam int SS = 2048;
  localparam int M_OFF = 0, M_COLD = 1, M_RUN = 2, M_DRAIN = 3, M_SLP = 4, M_WAKE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp3_n = 1'b0, slp5_n = 1'b0, bias_por_ok = 1'b0, rail12_por_ok = 1'b0, bkf_trip = 1'b0;
  logic sw_en, sb_en, tt_en, aux_en, bkf_rel, ref_short, ss_req, pg_cmp_en;

  always #10 clk = ~clk;

  sleep_pwr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .slp3_n(slp3_n), .slp5_n(slp5_n),
    .bias_por_ok(bias_por_ok), .rail12_por_ok(rail12_por_ok), .bkf_trip(bkf_trip),
    .sw_en(sw_en), .sb_en(sb_en), .tt_en(tt_en), .aux_en(aux_en),
    .bkf_rel(bkf_rel), .ref_short(ref_short), .ss_req(ss_req), .pg_cmp_en(pg_cmp_en)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  wire [7:0] dut_vec = {sw_en, sb_en, tt_en, aux_en, bkf_rel, ref_short, ss_req, pg_cmp_en};

  // Expected outputs {sw,sb,tt,aux,bkf,short,ss,pg} per model mode.
  function automatic logic [7:0] exp_vec(int m);
    case (m)
      M_COLD, M_WAKE: return 8'b1011_1010;
      M_RUN:          return 8'b1011_1001;
      M_DRAIN:        return 8'b1100_0100;
      M_SLP:          return 8'b0100_0100;
      default:        return 8'b0000_0000;
    endcase
  endfunction

  function automatic string tag_of(int m);
    case (m)
      M_COLD:  return "R3";
      M_RUN:   return "R5";
      M_DRAIN: return "R6";
      M_SLP:   return "R7";
      M_WAKE:  return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model of the requirements: {s3,s5,bias,r12,trip}.
  logic [4:0] m_s1, m_s2;
  int mode, left;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; mode <= M_OFF; left <= 0;
    end else begin
      m_s1 <= {slp3_n, slp5_n, bias_por_ok, rail12_por_ok, bkf_trip};
      m_s2 <= m_s1;
      if (!m_s2[3] || !m_s2[2]) mode <= M_OFF;
      else case (mode)
        M_OFF:   if (&m_s2) begin mode <= M_COLD; left <= 2*SS - 1; end
        M_COLD:  if (!m_s2[1]) mode <= M_OFF; else if (left == 0) mode <= M_RUN; else left <= left - 1;
        M_RUN:   if (!m_s2[1]) mode <= M_OFF; else if (!m_s2[4]) mode <= M_DRAIN;
        M_DRAIN: if (!m_s2[1]) mode <= M_OFF; else mode <= M_SLP;
        M_SLP:   if (m_s2[4] && m_s2[1]) begin mode <= M_WAKE; left <= SS - 1; end
        M_WAKE:  if (!m_s2[1]) mode <= M_OFF; else if (!m_s2[4]) mode <= M_DRAIN;
                 else if (left == 0) mode <= M_RUN; else left <= left - 1;
        default: mode <= M_OFF;
      endcase
    end
  end

  always @(negedge clk)
    if (rst_n && !finished) chk(dut_vec == exp_vec(mode), tag_of(mode), dut_vec, exp_vec(mode));

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic all_good();
    slp3_n = 1; slp5_n = 1; bias_por_ok = 1; rail12_por_ok = 1; bkf_trip = 1;
  endtask

  task automatic measure_ss(input string tag, input int exp_len);
    int n = 1;
    while (ss_req && n < 10*SS) begin ticks(1); if (ss_req) n++; end
    chk(n == exp_len, tag, 8'(n / SS), 8'(exp_len / SS));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    ticks(4);
    rst_n = 1'b1;
    ticks(1);
    chk(dut_vec == 8'h00, "R2 reset", dut_vec, 8'h00);

    // Trip flag missing: stay off (R3); slp3_n low: stay off (R3).
    slp3_n = 1; slp5_n = 1; bias_por_ok = 1; rail12_por_ok = 1; bkf_trip = 0;
    ticks(20);
    chk(dut_vec == 8'h00, "R3 no trip", dut_vec, 8'h00);
    bkf_trip = 1; slp3_n = 0;
    ticks(20);
    chk(dut_vec == 8'h00, "R3 sleep req held", dut_vec, 8'h00);

    // R1 latency, then cold sequence length with a light-sleep glitch (R4).
    slp3_n = 1;
    ticks(2);
    chk(dut_vec == 8'h00, "R1 too early", dut_vec, 8'h00);
    ticks(1);
    chk(dut_vec == exp_vec(M_COLD), "R1 third edge", dut_vec, exp_vec(M_COLD));
    begin
      int n = 1;
      while (ss_req && n < 10*SS) begin
        ticks(1);
        if (ss_req) n++;
        if (n == 100) slp3_n = 0;
        if (n == 400) chk(dut_vec == exp_vec(M_COLD), "R4 sleep ignored", dut_vec, exp_vec(M_COLD));
        if (n == 500) slp3_n = 1;
      end
      chk(n == 2*SS, "R3 cold length", 8'(n / SS), 8'd2);
    end
    chk(dut_vec == exp_vec(M_RUN), "R5 active", dut_vec, exp_vec(M_RUN));
    chk(pg_cmp_en == 1'b1, "R11 pg in active", {7'd0, pg_cmp_en}, 8'd1);

    // Sleep entry (R6).
    ticks(30);
    slp3_n = 0;
    ticks(3);
    chk(dut_vec == exp_vec(M_DRAIN), "R6 same edge", dut_vec, exp_vec(M_DRAIN));
    ticks(1);
    chk(dut_vec == exp_vec(M_SLP), "R6 switcher next", dut_vec, exp_vec(M_SLP));

    // 12 V loss ignored in sleep (R10), wake waits for 12 V (R7), wake length (R8).
    rail12_por_ok = 0;
    ticks(10);
    chk(dut_vec == exp_vec(M_SLP), "R10 12V ignored in sleep", dut_vec, exp_vec(M_SLP));
    slp3_n = 1;
    ticks(60);
    chk(dut_vec == exp_vec(M_SLP), "R7 waiting for 12V", dut_vec, exp_vec(M_SLP));
    rail12_por_ok = 1;
    ticks(3);
    chk(dut_vec == exp_vec(M_WAKE), "R7 wake", dut_vec, exp_vec(M_WAKE));
    measure_ss("R8 wake length", SS);
    chk(pg_cmp_en == 1'b1, "R8 pg after wake", {7'd0, pg_cmp_en}, 8'd1);

    // Deep shutdown (R9) and power-on-reset losses (R10).
    slp5_n = 0;
    ticks(3);
    chk(dut_vec == 8'h00, "R9 deep off", dut_vec, 8'h00);
    slp5_n = 1;
    ticks(3 + 2*SS + 5);
    chk(dut_vec == exp_vec(M_RUN), "R5 active again", dut_vec, exp_vec(M_RUN));
    bias_por_ok = 0;
    ticks(3);
    chk(dut_vec == 8'h00, "R10 bias loss", dut_vec, 8'h00);
    bias_por_ok = 1;
    ticks(3 + 100);
    rail12_por_ok = 0;
    ticks(3);
    chk(dut_vec == 8'h00, "R10 12V loss in cold", dut_vec, 8'h00);

    // Random phase checked by the model each clock.
    all_good();
    for (int i = 0; i < 40; i++) begin
      int pick = $urandom_range(0, 9);
      case (pick)
        0:       slp5_n = ~slp5_n;
        1:       bias_por_ok = ~bias_por_ok;
        2, 3:    rail12_por_ok = ~rail12_por_ok;
        4:       bkf_trip = ~bkf_trip;
        default: slp3_n = ~slp3_n;
      endcase
      if (!slp5_n && $urandom_range(0, 1) == 1) slp5_n = 1;
      if (!bias_por_ok && $urandom_range(0, 1) == 1) bias_por_ok = 1;
      ticks($urandom_range(1, 2500));
    end

    all_good();
    ticks(3 + 2*SS + 10);
    finish_run();
  end

endmodule